// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block is the device side of a byte-wide nonvolatile memory that a host reaches through an asynchronous, SRAM-style interface. The interface has active-low chip-enable, output-enable and write-enable strobes, a 13-bit address and an 8-bit data path. The storage is an 8192 x 8 array built from registers. A second, 32-byte identification store sits beside it. All strobes, flags and buses are brought into the system clock domain through a two-flop synchroniser, and every edge is detected on the synchronised copies. Every delay is a parameterised count of clock cycles.

A host write pulse works like this. Address capture happens when the pulse opens, on the later of the two falling strobes. Data capture happens when the pulse closes, on the first strobe that rises. The block then runs its own timed cycle, so the host bus is free again. The target byte is first set to all ones, and the latched data is written at the end of the timed interval. While the cycle runs, an open-drain busy pull-down is active. A read of the byte being written returns its bit 7 inverted, which gives the host a second way to poll for completion.

Writes are blocked by bad strobe combinations, by a supply-low flag, and by a lockout window after the supply becomes valid. Holding the clear condition with both strobes low for long enough sets the whole main array to all ones.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset, `busy_pull` is 0 and `dout_en` is 0.
- R2: `dout_en` is 1 exactly when the pins showed ce_n=0, oe_n=0 and we_n=1 four clock edges earlier. While `dout_en` is 0, `dout` is all zeros. While it is 1, `dout` carries the byte stored at `addr`.
- R3: A write opens when ce_n=0, we_n=0 and oe_n=1. The address is taken when the pulse opens and the data when it closes. After the cycle, the addressed byte holds that data and no other byte changes.
- R4: While a write cycle runs, a read of the target address returns the inverse of the new data's bit 7 on `dout[7]`. After completion, all 8 bits read back true.
- R5: A byte-write cycle keeps `busy_pull` at 1 for exactly WRITE_CYC+1 consecutive cycles. A chip clear keeps it at 1 for 2^ADDR_W cycles.
- R6: A pulse with oe_n=0, or a we_n pulse while ce_n=1, starts no cycle and changes no byte.
- R7: While `supply_low` is 1, no write or clear cycle starts.
- R8: For PON_CYC cycles after `supply_low` falls (and after reset), no write or clear cycle starts.
- R9: Write pulses that begin while `busy_pull` is 1 are ignored.
- R10: If `clr_mode`=1, ce_n=0 and we_n=0 are held for CLR_CYC cycles, every main-array byte becomes 8'hFF. A shorter hold has no effect, and while `clr_mode` is 1 no byte write occurs.
- R11: With `id_mode`=1, addresses 1FE0h-1FFFh (upper 8 address bits all ones) read and write the separate 32-byte identification store. The main bytes at those addresses are untouched. With `id_mode`=0, those addresses reach the main array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from host |
| supply_low | input | 1 | Supply below write threshold |
| id_mode | input | 1 | Selects the identification store for the top 32 addresses |
| clr_mode | input | 1 | Clear condition for whole-array clear |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |
| busy_pull | output | 1 | Open-drain pull-down enable, 1 while a cycle runs |

## Verification
A wrong internal state shows at the ports within a few cycles. A bad timing counter or a stuck state changes the length of the `busy_pull` window, and a checker counter measures that length on every falling edge. A wrong latch of address or data shows in the first readback after the cycle, four cycles after the read strobes. A bad polling match shows while the cycle is still running, as a wrong `dout[7]`. Missed inhibit or lockout logic shows as a busy rise that should not happen, and the bench also catches it as a changed byte.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ERASE,
    ST_PROG,
    ST_SWEEP
  } wr_state_t;
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/nvb_engine.sv
module nvb_engine
  import nvb_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int WRITE_CYC = 25000,
  parameter int PON_CYC   = 625000,
  parameter int CLR_CYC   = 1250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          low_s,
  input  logic          clr_s,
  input  logic          win_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] din_s,
  output logic          wr_main,
  output logic          wr_id,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy_q,
  output logic          poll_on,
  output logic          poll_id,
  output logic [AW-1:0] poll_addr,
  output logic          poll_bit
);
  localparam int TW = $clog2(WRITE_CYC + 1);
  localparam int PW = $clog2(PON_CYC + 1);
  localparam int KW = $clog2(CLR_CYC + 1);

  wr_state_t     state, nxt;
  logic          wr_act, wr_act_q, start, stop;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pon_cnt;
  logic [KW-1:0] clr_cnt;
  logic [AW-1:0] lat_addr, sweep_addr;
  logic [DW-1:0] lat_data;
  logic          lat_id;
  logic          pon_done, clr_hold, clr_fire, prog_done, permit;

  // a write pulse is open while both strobes are low with output enable high
  assign wr_act    = ~ce_s & ~we_s & oe_s & ~clr_s;
  assign start     = wr_act & ~wr_act_q;
  assign stop      = ~wr_act & wr_act_q;
  assign pon_done  = (pon_cnt == PW'(PON_CYC));
  assign permit    = ~low_s & pon_done;
  assign clr_hold  = clr_s & ~ce_s & ~we_s;
  assign clr_fire  = clr_hold && (clr_cnt == KW'(CLR_CYC - 1)) &&
                     (state == ST_IDLE) && permit;
  assign prog_done = (state == ST_PROG) && (tcnt == TW'(WRITE_CYC - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (clr_fire) nxt = ST_SWEEP;
                else if (start && permit) nxt = ST_ARMED;
      ST_ARMED: if (low_s) nxt = ST_IDLE;
                else if (stop) nxt = ST_ERASE;
      ST_ERASE: nxt = ST_PROG;
      ST_PROG:  if (prog_done) nxt = ST_IDLE;
      ST_SWEEP: if (&sweep_addr) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_act_q   <= 1'b0;
      busy_q     <= 1'b0;
      tcnt       <= '0;
      pon_cnt    <= '0;
      clr_cnt    <= '0;
      lat_addr   <= '0;
      lat_data   <= '0;
      lat_id     <= 1'b0;
      sweep_addr <= '0;
    end else begin
      state    <= nxt;
      wr_act_q <= wr_act;
      busy_q   <= (nxt == ST_ERASE) || (nxt == ST_PROG) || (nxt == ST_SWEEP);

      if (low_s) pon_cnt <= '0;
      else if (!pon_done) pon_cnt <= pon_cnt + 1'b1;

      if (!clr_hold) clr_cnt <= '0;
      else if (clr_cnt != KW'(CLR_CYC)) clr_cnt <= clr_cnt + 1'b1;

      if (state == ST_IDLE && nxt == ST_ARMED) begin
        lat_addr <= addr_s;
        lat_id   <= win_s;
      end
      if (state == ST_ARMED && nxt == ST_ERASE) lat_data <= din_s;

      if (state == ST_ERASE) tcnt <= '0;
      else if (state == ST_PROG) tcnt <= tcnt + 1'b1;

      if (clr_fire) sweep_addr <= '0;
      else if (state == ST_SWEEP) sweep_addr <= sweep_addr + 1'b1;
    end
  end

  always_comb begin
    wr_main = 1'b0;
    wr_id   = 1'b0;
    wr_addr = lat_addr;
    wr_data = lat_data;
    if (state == ST_SWEEP) begin
      wr_main = 1'b1;
      wr_addr = sweep_addr;
      wr_data = '1;
    end else if (state == ST_ERASE || prog_done) begin
      wr_main = ~lat_id;
      wr_id   = lat_id;
      if (state == ST_ERASE) wr_data = '1;
    end
  end

  assign poll_on   = (state == ST_ERASE) || (state == ST_PROG);
  assign poll_id   = lat_id;
  assign poll_addr = lat_addr;
  assign poll_bit  = lat_data[DW-1];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ID_W      = 5,
  parameter int WRITE_CYC = 25000,
  parameter int PON_CYC   = 625000,
  parameter int CLR_CYC   = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              supply_low,
  input  logic              id_mode,
  input  logic              clr_mode,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy_pull
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic              ce_s, oe_s, we_s, low_s, id_s, clr_s, win_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  nvb_sync #(.W(6), .STAGES(2), .RST_VAL(6'b111100)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({ce_n, oe_n, we_n, supply_low, id_mode, clr_mode}),
    .q({ce_s, oe_s, we_s, low_s, id_s, clr_s})
  );

  nvb_sync #(.W(BUS_W), .STAGES(2), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst),
    .d({addr, din}),
    .q({addr_s, din_s})
  );

  assign win_s = id_s & (&addr_s[ADDR_W-1:ID_W]);

  logic              wr_main, wr_id, poll_on, poll_id, poll_bit;
  logic [ADDR_W-1:0] wr_addr, poll_addr;
  logic [DATA_W-1:0] wr_data, main_rd, id_rd;

  nvb_engine #(
    .AW(ADDR_W), .DW(DATA_W), .WRITE_CYC(WRITE_CYC),
    .PON_CYC(PON_CYC), .CLR_CYC(CLR_CYC)
  ) u_eng (
    .clk(clk), .rst(rst),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .low_s(low_s), .clr_s(clr_s),
    .win_s(win_s), .addr_s(addr_s), .din_s(din_s),
    .wr_main(wr_main), .wr_id(wr_id), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_q(busy_pull), .poll_on(poll_on), .poll_id(poll_id),
    .poll_addr(poll_addr), .poll_bit(poll_bit)
  );

  nvb_store #(.AW(ADDR_W), .DW(DATA_W)) u_main (
    .clk(clk), .we(wr_main), .wa(wr_addr), .wd(wr_data),
    .ra(addr_s), .rd(main_rd)
  );

  nvb_store #(.AW(ID_W), .DW(DATA_W)) u_ident (
    .clk(clk), .we(wr_id), .wa(wr_addr[ID_W-1:0]), .wd(wr_data),
    .ra(addr_s[ID_W-1:0]), .rd(id_rd)
  );

  // stage 1 runs alongside the synchronous store read
  logic en1, sel1, hit1, pbit1;
  always_ff @(posedge clk) begin
    if (rst) begin
      en1 <= 1'b0; sel1 <= 1'b0; hit1 <= 1'b0; pbit1 <= 1'b0;
    end else begin
      en1   <= ~ce_s & ~oe_s & we_s;
      sel1  <= win_s;
      hit1  <= poll_on && (addr_s == poll_addr) && (win_s == poll_id);
      pbit1 <= poll_bit;
    end
  end

  logic [DATA_W-1:0] byte1;
  assign byte1 = sel1 ? id_rd : main_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= en1;
      if (!en1) dout <= '0;
      else dout <= {hit1 ? ~pbit1 : byte1[DATA_W-1], byte1[DATA_W-2:0]};
    end
  end
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
  parameter int WRITE_CYC = 25000,
  parameter int PON_CYC   = 625000,
  parameter int DEPTH     = 8192,
  parameter int DW        = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          supply_low,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          busy_pull
);
  int seen, blen, pin_pon;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 0; blen <= 0; pin_pon <= 0;
    end else begin
      if (seen < 7) seen <= seen + 1;
      blen <= busy_pull ? blen + 1 : 0;
      if (supply_low) pin_pon <= 0;
      else if (pin_pon < PON_CYC) pin_pon <= pin_pon + 1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_pull && !dout_en));

  a_r2_read_enable: assert property (@(posedge clk) disable iff (rst)
    (seen >= 6) |-> (dout_en == $past(~ce_n & ~oe_n & we_n, 4)));

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

  a_r5_busy_window: assert property (@(posedge clk) disable iff (rst)
    (!busy_pull && blen != 0) |-> (blen == WRITE_CYC + 1 || blen == DEPTH));

  a_r7_no_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_pull) |-> !$past(supply_low, 3));

  a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_pull) |-> (pin_pon >= PON_CYC));
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
  .WRITE_CYC(WRITE_CYC), .PON_CYC(PON_CYC), .DEPTH(1 << ADDR_W), .DW(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .supply_low(supply_low), .dout(dout), .dout_en(dout_en), .busy_pull(busy_pull)
);

// File: tb/sim_nvbyte_ctrl.sv
module sim_nvbyte_ctrl;
  localparam int AW = 13, DW = 8, WCYC = 40, PCYC = 60, CCYC = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic supply_low = 1'b0, id_mode = 1'b0, clr_mode = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en, busy_pull;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nvbyte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ID_W(5), .WRITE_CYC(WCYC),
                .PON_CYC(PCYC), .CLR_CYC(CCYC)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .supply_low(supply_low), .id_mode(id_mode),
    .clr_mode(clr_mode), .dout(dout), .dout_en(dout_en), .busy_pull(busy_pull)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_write(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1; ce_n = 1'b1;
    cyc(4);
  endtask

  task automatic read_byte(logic [AW-1:0] a, output logic [DW-1:0] v, output logic en);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(6);
    v = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(5);
  endtask

  task automatic wait_idle();
    cyc(3);
    for (int i = 0; i < 20000 && busy_pull; i++) cyc(1);
  endtask

  task automatic busy_seen(int n, output bit s);
    s = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (busy_pull) s = 1'b1;
    end
  endtask

  task automatic expect_byte(string tag, logic [AW-1:0] a, logic [DW-1:0] e);
    logic [DW-1:0] v; logic en;
    read_byte(a, v, en);
    chk(tag, {en, v}, {1'b1, e});
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy_pull, 0);
    chk("R1 dout_en after reset", dout_en, 0);
  endtask

  task automatic t_clear();
    bit s;
    clr_mode = 1'b1; cyc(3);
    ce_n = 1'b0; we_n = 1'b0;
    busy_seen(CCYC / 2, s);
    ce_n = 1'b1; we_n = 1'b1; cyc(3); clr_mode = 1'b0;
    busy_seen(6, s);
    chk("R10 short clear hold ignored", s, 0);
    clr_mode = 1'b1; cyc(3);
    ce_n = 1'b0; we_n = 1'b0;
    busy_seen(CCYC + 10, s);
    ce_n = 1'b1; we_n = 1'b1; cyc(3); clr_mode = 1'b0;
    chk("R10 full clear starts", s, 1);
    wait_idle();
    expect_byte("R10 byte 0000 cleared", 13'h0000, 8'hFF);
    expect_byte("R10 byte 1FFF cleared", 13'h1FFF, 8'hFF);
    expect_byte("R10 byte 0ABC cleared", 13'h0ABC, 8'hFF);
  endtask

  task automatic t_busy_len();
    int cnt = 0;
    addr = 13'h0200; din = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1; ce_n = 1'b1;
    for (int i = 0; i < WCYC + 30; i++) begin
      cyc(1);
      if (busy_pull) cnt++;
    end
    chk("R5 busy length", cnt, WCYC + 1);
    expect_byte("R3 basic write", 13'h0200, 8'h5A);
  endtask

  task automatic t_poll();
    logic [DW-1:0] v; logic en;
    pulse_write(13'h0123, 8'hC3);
    read_byte(13'h0123, v, en);
    chk("R4 poll bit7 inverted", {en, v[7]}, {1'b1, 1'b0});
    chk("R4 still busy while polling", busy_pull, 1);
    wait_idle();
    expect_byte("R4 true data after cycle", 13'h0123, 8'hC3);
  endtask

  task automatic t_strobe_order();
    addr = 13'h0300; din = 8'h11; we_n = 1'b0; cyc(3);
    addr = 13'h0301; ce_n = 1'b0; cyc(3);
    addr = 13'h0302; din = 8'h6E; cyc(3);
    ce_n = 1'b1; cyc(2); we_n = 1'b1;
    wait_idle();
    expect_byte("R3 address at later falling strobe", 13'h0301, 8'h6E);
    expect_byte("R3 first address untouched", 13'h0300, 8'hFF);
    expect_byte("R3 address change after open untouched", 13'h0302, 8'hFF);
  endtask

  task automatic t_inhibit();
    bit s;
    addr = 13'h0060; din = 8'h77; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    busy_seen(8, s);
    chk("R6 oe low no cycle", s, 0);
    expect_byte("R6 oe low byte kept", 13'h0060, 8'hFF);
    addr = 13'h0061; din = 8'h22; we_n = 1'b0; cyc(4); we_n = 1'b1;
    busy_seen(8, s);
    chk("R6 ce high no cycle", s, 0);
    expect_byte("R6 ce high byte kept", 13'h0061, 8'hFF);
  endtask

  task automatic t_supply();
    bit s;
    supply_low = 1'b1; cyc(4);
    pulse_write(13'h0050, 8'h12);
    busy_seen(6, s);
    chk("R7 supply low no cycle", s, 0);
    expect_byte("R7 supply low byte kept", 13'h0050, 8'hFF);
    supply_low = 1'b0; cyc(2);
    pulse_write(13'h0050, 8'h12);
    busy_seen(6, s);
    chk("R8 lockout no cycle", s, 0);
    expect_byte("R8 lockout byte kept", 13'h0050, 8'hFF);
    cyc(PCYC + 10);
    pulse_write(13'h0050, 8'h12);
    wait_idle();
    expect_byte("R8 write after lockout", 13'h0050, 8'h12);
  endtask

  task automatic t_ignore_busy();
    pulse_write(13'h0400, 8'h3D);
    pulse_write(13'h0401, 8'h44);
    wait_idle();
    expect_byte("R9 first write done", 13'h0400, 8'h3D);
    expect_byte("R9 pulse during busy ignored", 13'h0401, 8'hFF);
  endtask

  task automatic t_ident();
    id_mode = 1'b1; cyc(3);
    pulse_write(13'h1FE3, 8'h3C);
    wait_idle();
    expect_byte("R11 id store readback", 13'h1FE3, 8'h3C);
    pulse_write(13'h1000, 8'h81);
    wait_idle();
    id_mode = 1'b0; cyc(3);
    expect_byte("R11 main byte at id address untouched", 13'h1FE3, 8'hFF);
    expect_byte("R11 low address goes to main", 13'h1000, 8'h81);
  endtask

  task automatic t_read_enable();
    addr = 13'h0200; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    cyc(6);
    chk("R2 oe high no drive", {dout_en, dout}, 0);
    ce_n = 1'b1; oe_n = 1'b0; cyc(6);
    chk("R2 ce high no drive", {dout_en, dout}, 0);
    oe_n = 1'b1; cyc(2);
    expect_byte("R2 read drives stored byte", 13'h0200, 8'h5A);
    chk("R2 released after read", {dout_en, dout}, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    t_reset();
    cyc(PCYC + 10);
    t_clear();
    t_busy_len();
    t_poll();
    t_strobe_order();
    t_inhibit();
    t_supply();
    t_ignore_busy();
    t_ident();
    t_read_enable();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule